// File: doc/BRIEF.md
# Interval Timer and Parallel Port Register Unit

This block is a small memory-mapped peripheral for a synchronous CPU-style bus. It holds two 8-bit parallel ports, each with an output register and a per-bit direction register. It also has two down-counting interval timers and an interrupt controller with a flag register and an enable register. A chip select, a write strobe, a 4-bit register select and 8-bit write data address the registers. Read data is registered and appears on the cycle after the read.

Timer 1 is 16 bits wide and has a separate 16-bit reload latch. Writing the latch high byte copies the latch into the counter and starts the timer. Timer 2 is 8 bits wide and starts when its counter byte is written. Each running timer counts down by one every clock. When it reaches zero it raises its flag and then holds at zero. The interrupt request output goes low while any flag is set together with its enable bit.

Top module: `io_timer_adapter`

## Requirements
- R1: After reset every register is zero, `irq_no` is high, both ports drive nothing, and `rdata_o` is 0.
- R2: Select 0 is the port B output register, 1 the port A output register, 2 the port B direction register and 3 the port A direction register. A written value reads back. Each `p*_oe_o` bit equals its direction bit. Each `p*_o` bit equals the output bit where the direction bit is 1 and is 0 where it is 0.
- R3: A write to select 4 stores the timer-1 latch low byte and copies the whole 16-bit latch into the counter. It does not start a stopped timer.
- R4: A write to select 5 stores the latch high byte, copies the latch into the counter and starts timer 1.
- R5: Writes to select 6 (latch low) and select 7 (latch high) change only that latch byte and leave the counter unchanged. Select 4 reads the counter low byte, 5 the counter high byte, 6 the latch low byte and 7 the latch high byte.
- R6: A running timer with a nonzero count decrements once per clock. The clock edge that brings timer 1 to zero sets flag bit 6, and the counter then stays at zero. A timer started at zero sets no flag.
- R7: A write to select 8 loads the 8-bit timer-2 counter and starts timer 2. Select 9 is a latch byte that reads back and does not touch the counter. Timer 2 reaching zero sets flag bit 5.
- R8: A write to select 0xD clears every flag bit that is 1 in the written value. If a timer sets a flag on the same edge, the set wins.
- R9: A write to select 0xE with bit 7 = 1 sets the enable bits that are 1 in bits 6:0. With bit 7 = 0 it clears them.
- R10: Reading select 0xE returns the enable bits with bit 7 forced to 1. Reading select 0xD returns the flags in bits 6:0 and, in bit 7, the OR of flags AND enables. Selects 0xA, 0xB, 0xC and 0xF read as 0 and ignore writes.
- R11: `irq_no` is low exactly when some flag bit and its enable bit are both 1.
- R12: Read data appears on `rdata_o` in the cycle after a read is presented. `rdata_o` is 0 in any cycle that follows a non-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| we_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 4 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pa_o | output | 8 | Port A pin values (driven bits only) |
| pa_oe_o | output | 8 | Port A output enables |
| pb_o | output | 8 | Port B pin values (driven bits only) |
| pb_oe_o | output | 8 | Port B output enables |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench counts the edges from a timer start to the fall of `irq_no` for several loads. A counter that is off by one at load or at zero shows up as a wrong edge count. A timer that wraps past zero or keeps counting would show a nonzero counter read after expiry. A timer started at zero that raised a flag would show a spurious flag.

Latch-only writes are checked by reading the counter back. Writing the timer-1 low byte must load the counter without starting it.

A flag clear is placed on the exact edge where timer 1 expires. If the design let the clear win, the event would be lost. The enable register is swept over all 128 masks in both its set and clear forms, so a design that ignored bit 7 or cleared the wrong bits would mismatch.

// File: rtl/ioa_pkg.sv
package ioa_pkg;
  localparam int unsigned SEL_W = 4;

  localparam logic [SEL_W-1:0] SEL_OUT_B     = 4'h0;
  localparam logic [SEL_W-1:0] SEL_OUT_A     = 4'h1;
  localparam logic [SEL_W-1:0] SEL_DIR_B     = 4'h2;
  localparam logic [SEL_W-1:0] SEL_DIR_A     = 4'h3;
  localparam logic [SEL_W-1:0] SEL_T1_CNT_LO = 4'h4;
  localparam logic [SEL_W-1:0] SEL_T1_CNT_HI = 4'h5;
  localparam logic [SEL_W-1:0] SEL_T1_LAT_LO = 4'h6;
  localparam logic [SEL_W-1:0] SEL_T1_LAT_HI = 4'h7;
  localparam logic [SEL_W-1:0] SEL_T2_CNT    = 4'h8;
  localparam logic [SEL_W-1:0] SEL_T2_LAT    = 4'h9;
  localparam logic [SEL_W-1:0] SEL_FLAGS     = 4'hD;
  localparam logic [SEL_W-1:0] SEL_ENABLE    = 4'hE;

  localparam int unsigned FLG_T1 = 6;
  localparam int unsigned FLG_T2 = 5;
  localparam int unsigned N_PORTS = 2;
endpackage

// File: rtl/ioa_port.sv
module ioa_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_out_i,
  input  logic         wr_dir_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] out_q_o,
  output logic [W-1:0] dir_q_o,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o
);
  logic [W-1:0] out_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_out_i) out_q <= wdata_i;
      if (wr_dir_i) dir_q <= wdata_i;
    end
  end

  assign out_q_o  = out_q;
  assign dir_q_o  = dir_q;
  assign pin_oe_o = dir_q;
  assign pin_o    = out_q & dir_q;

  a_r2_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_out_i |=> $stable(out_q));
  a_r2_dir_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_i |=> (pin_oe_o == $past(wdata_i)));
endmodule

// File: rtl/ioa_timer.sv
module ioa_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      if (start_i) run_q <= 1'b1;
    end else if (run_q && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // expiry pulse on the edge that reaches zero; a load that cycle takes priority
  assign evt_o = run_q && !load_i && (cnt_q == ONE);
  assign cnt_o = cnt_q;

  a_r6_dec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
  a_r6_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
  a_r4_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && start_i) |=> run_q);
endmodule

// File: rtl/ioa_irq.sv
module ioa_irq #(
  parameter int unsigned W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-2:0]   set_i,
  input  logic           clr_wr_i,
  input  logic           ena_wr_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-2:0]   flags_o,
  output logic [W-2:0]   ena_o,
  output logic           any_o
);
  localparam int unsigned FLAG_W = W - 1;

  logic [FLAG_W-1:0] flags_q, ena_q, clr_mask;

  assign clr_mask = clr_wr_i ? wdata_i[FLAG_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      ena_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_mask) | set_i;
      if (ena_wr_i) begin
        if (wdata_i[W-1]) ena_q <= ena_q | wdata_i[FLAG_W-1:0];
        else              ena_q <= ena_q & ~wdata_i[FLAG_W-1:0];
      end
    end
  end

  assign flags_o = flags_q;
  assign ena_o   = ena_q;
  assign any_o   = |(flags_q & ena_q);

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && ((set_i & wdata_i[FLAG_W-1:0]) == '0))
      |=> ((flags_q & $past(wdata_i[FLAG_W-1:0])) == '0));
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));
  a_r9_ena_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_wr_i && wdata_i[W-1])
      |=> ((ena_q & $past(wdata_i[FLAG_W-1:0])) == $past(wdata_i[FLAG_W-1:0])));
  a_r9_ena_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_wr_i && !wdata_i[W-1]) |=> ((ena_q & $past(wdata_i[FLAG_W-1:0])) == '0));
endmodule

// File: rtl/io_timer_adapter.sv
module io_timer_adapter
  import ioa_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] pa_o,
  output logic [DATA_W-1:0] pa_oe_o,
  output logic [DATA_W-1:0] pb_o,
  output logic [DATA_W-1:0] pb_oe_o,
  output logic              irq_no
);
  localparam int unsigned T1_W   = 2 * DATA_W;
  localparam int unsigned T2_W   = DATA_W;
  localparam int unsigned FLAG_W = DATA_W - 1;

  logic wr, rd;
  assign wr = cs_i &  we_i;
  assign rd = cs_i & ~we_i;

  // ports: index 0 = A, 1 = B
  logic [DATA_W-1:0] out_q [N_PORTS];
  logic [DATA_W-1:0] dir_q [N_PORTS];
  logic [DATA_W-1:0] pin   [N_PORTS];
  logic [DATA_W-1:0] pin_oe[N_PORTS];
  localparam logic [SEL_W-1:0] OUT_SEL [N_PORTS] = '{SEL_OUT_A, SEL_OUT_B};
  localparam logic [SEL_W-1:0] DIR_SEL [N_PORTS] = '{SEL_DIR_A, SEL_DIR_B};

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    ioa_port #(.W(DATA_W)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_out_i (wr && sel_i == OUT_SEL[g]),
      .wr_dir_i (wr && sel_i == DIR_SEL[g]),
      .wdata_i  (wdata_i),
      .out_q_o  (out_q[g]),
      .dir_q_o  (dir_q[g]),
      .pin_o    (pin[g]),
      .pin_oe_o (pin_oe[g])
    );
  end

  assign pa_o    = pin[0];
  assign pa_oe_o = pin_oe[0];
  assign pb_o    = pin[1];
  assign pb_oe_o = pin_oe[1];

  // timer 1 latch and counter
  logic [T1_W-1:0] t1_lat_q, t1_cnt, t1_load_val;
  logic            t1_wr_lo, t1_wr_hi, t1_evt;
  assign t1_wr_lo = wr && sel_i == SEL_T1_CNT_LO;
  assign t1_wr_hi = wr && sel_i == SEL_T1_CNT_HI;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_lat_q <= '0;
    end else begin
      if (t1_wr_lo || (wr && sel_i == SEL_T1_LAT_LO)) t1_lat_q[DATA_W-1:0]    <= wdata_i;
      if (t1_wr_hi || (wr && sel_i == SEL_T1_LAT_HI)) t1_lat_q[T1_W-1:DATA_W] <= wdata_i;
    end
  end

  assign t1_load_val = t1_wr_hi ? {wdata_i, t1_lat_q[DATA_W-1:0]}
                                : {t1_lat_q[T1_W-1:DATA_W], wdata_i};

  ioa_timer #(.CNT_W(T1_W)) u_t1 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t1_wr_lo | t1_wr_hi),
    .start_i    (t1_wr_hi),
    .load_val_i (t1_load_val),
    .cnt_o      (t1_cnt),
    .evt_o      (t1_evt)
  );

  // timer 2
  logic [T2_W-1:0]   t2_cnt, t2_lat_q;
  logic              t2_wr, t2_evt;
  assign t2_wr = wr && sel_i == SEL_T2_CNT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         t2_lat_q <= '0;
    else if (wr && sel_i == SEL_T2_LAT)  t2_lat_q <= wdata_i;
  end

  ioa_timer #(.CNT_W(T2_W)) u_t2 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t2_wr),
    .start_i    (t2_wr),
    .load_val_i (wdata_i),
    .cnt_o      (t2_cnt),
    .evt_o      (t2_evt)
  );

  // interrupts
  logic [FLAG_W-1:0] flag_set, flags, ena;
  logic              irq_any;

  always_comb begin
    flag_set         = '0;
    flag_set[FLG_T1] = t1_evt;
    flag_set[FLG_T2] = t2_evt;
  end

  ioa_irq #(.W(DATA_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (flag_set),
    .clr_wr_i (wr && sel_i == SEL_FLAGS),
    .ena_wr_i (wr && sel_i == SEL_ENABLE),
    .wdata_i  (wdata_i),
    .flags_o  (flags),
    .ena_o    (ena),
    .any_o    (irq_any)
  );

  assign irq_no = ~irq_any;

  // read path
  logic [DATA_W-1:0] rd_val, rdata_q;

  always_comb begin
    case (sel_i)
      SEL_OUT_B:     rd_val = out_q[1];
      SEL_OUT_A:     rd_val = out_q[0];
      SEL_DIR_B:     rd_val = dir_q[1];
      SEL_DIR_A:     rd_val = dir_q[0];
      SEL_T1_CNT_LO: rd_val = t1_cnt[DATA_W-1:0];
      SEL_T1_CNT_HI: rd_val = t1_cnt[T1_W-1:DATA_W];
      SEL_T1_LAT_LO: rd_val = t1_lat_q[DATA_W-1:0];
      SEL_T1_LAT_HI: rd_val = t1_lat_q[T1_W-1:DATA_W];
      SEL_T2_CNT:    rd_val = t2_cnt;
      SEL_T2_LAT:    rd_val = t2_lat_q;
      SEL_FLAGS:     rd_val = {irq_any, flags};
      SEL_ENABLE:    rd_val = {1'b1, ena};
      default:       rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
    else          rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  a_r12_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && !we_i) |=> (rdata_o == '0));
  a_r10_enable_b7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && sel_i == SEL_ENABLE) |=> rdata_o[DATA_W-1]);
  a_r11_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && sel_i == SEL_ENABLE && wdata_i == {1'b0, {FLAG_W{1'b1}}}) |=> irq_no);
endmodule

// File: tb/io_timer_adapter_tb.sv
module io_timer_adapter_tb;
  logic       clk = 1'b0;
  logic       rst_n, cs, we;
  logic [3:0] sel;
  logic [7:0] wd, rdata, pa, pa_oe, pb, pb_oe;
  logic       irq_n;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  io_timer_adapter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .sel_i(sel), .wdata_i(wd),
    .rdata_o(rdata), .pa_o(pa), .pa_oe_o(pa_oe), .pb_o(pb), .pb_oe_o(pb_oe), .irq_no(irq_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    cs = 1'b1; we = 1'b1; sel = s; wd = d;
    @(posedge clk); @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d);
    cs = 1'b1; we = 1'b0; sel = s;
    @(posedge clk); @(negedge clk);
    cs = 1'b0;
    d = rdata;
  endtask

  task automatic rdchk(input string req, input logic [3:0] s, input logic [7:0] e);
    logic [7:0] v;
    rd(s, v);
    chk(req, {8'h0, v}, {8'h0, e});
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic edges_to_irq(output int k, input int lim);
    k = 0;
    while (irq_n === 1'b1 && k < lim) begin
      @(posedge clk); @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int k;
    logic [7:0] v;
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; sel = '0; wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", {8'h0, rdata}, 16'h0);
    chk("R1 irq_no", {15'h0, irq_n}, 16'h1);
    chk("R1 pa_oe", {8'h0, pa_oe}, 16'h0);
    chk("R1 pb_oe", {8'h0, pb_oe}, 16'h0);
    rdchk("R1 enable", 4'hE, 8'h80);
    rdchk("R1 flags", 4'hD, 8'h00);
    rdchk("R1 t1 cnt lo", 4'h4, 8'h00);
    // R12 idle cycle after read gives zero
    idle(1);
    chk("R12 idle zero", {8'h0, rdata}, 16'h0);

    // R2 port sweep
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d;
      d = 8'(i) ^ 8'h5A;
      wr(4'h1, 8'(i)); wr(4'h3, d);
      chk("R2 pa_o", {8'h0, pa}, {8'h0, 8'(i) & d});
      chk("R2 pa_oe", {8'h0, pa_oe}, {8'h0, d});
      rdchk("R2 out A", 4'h1, 8'(i));
      rdchk("R2 dir A", 4'h3, d);
    end
    for (int i = 0; i < 256; i += 3) begin
      logic [7:0] d;
      d = ~8'(i);
      wr(4'h0, 8'(i)); wr(4'h2, d);
      chk("R2 pb_o", {8'h0, pb}, {8'h0, 8'(i) & d});
      chk("R2 pb_oe", {8'h0, pb_oe}, {8'h0, d});
      rdchk("R2 out B", 4'h0, 8'(i));
      rdchk("R2 dir B", 4'h2, d);
    end

    // R10 unmapped selects
    for (int s = 10; s < 16; s++) begin
      if (s == 13 || s == 14) continue;
      wr(4'(s), 8'hFF);
      rdchk("R10 unmapped", 4'(s), 8'h00);
    end

    // R9 enable set/clear sweep
    for (int m = 0; m < 128; m++) begin
      wr(4'hE, 8'h7F);
      wr(4'hE, 8'h80 | 8'(m));
      rdchk("R9 set", 4'hE, 8'h80 | 8'(m));
      wr(4'hE, 8'(m) & 8'h55);
      rdchk("R9 clear", 4'hE, 8'h80 | (8'(m) & 8'h2A));
    end
    wr(4'hE, 8'h7F);
    wr(4'hE, 8'hC0);
    chk("R11 no flags", {15'h0, irq_n}, 16'h1);

    // R3/R5 latch versus counter, timer 1 not yet started
    wr(4'h4, 8'h34);
    rdchk("R3 cnt lo", 4'h4, 8'h34);
    rdchk("R3 no start", 4'h4, 8'h34);
    wr(4'h7, 8'h12);
    rdchk("R5 cnt hi unchanged", 4'h5, 8'h00);
    rdchk("R5 lat hi", 4'h7, 8'h12);
    rdchk("R5 lat lo", 4'h6, 8'h34);
    wr(4'h6, 8'h56);
    rdchk("R5 cnt lo unchanged", 4'h4, 8'h34);
    wr(4'h4, 8'h78);
    rdchk("R3 full copy lo", 4'h4, 8'h78);
    rdchk("R3 full copy hi", 4'h5, 8'h12);

    // R4 start with latch hi = 0 -> count 0x0078
    wr(4'h5, 8'h00);
    edges_to_irq(k, 300);
    chk("R6 t1 120 edges", 16'(k), 16'd120);
    rdchk("R10 flags bit7", 4'hD, 8'hC0);
    rdchk("R6 stays zero lo", 4'h4, 8'h00);
    rdchk("R6 stays zero hi", 4'h5, 8'h00);

    // R4 high-byte load: 0x0102 = 258
    wr(4'hD, 8'h7F);
    chk("R11 cleared", {15'h0, irq_n}, 16'h1);
    wr(4'h6, 8'h02);
    wr(4'h5, 8'h01);
    edges_to_irq(k, 400);
    chk("R4 t1 258 edges", 16'(k), 16'd258);

    // R6 decrement visible through reads
    wr(4'hD, 8'h7F);
    wr(4'h6, 8'h10);
    wr(4'h5, 8'h00);
    rdchk("R6 first read", 4'h4, 8'h10);
    rdchk("R6 one per clock", 4'h4, 8'h0F);
    edges_to_irq(k, 50);
    chk("R6 remaining edges", 16'(k), 16'd14);

    // R6 start at zero: no flag
    wr(4'hD, 8'h7F);
    wr(4'h6, 8'h00);
    wr(4'h5, 8'h00);
    idle(5);
    rdchk("R6 zero start no flag", 4'hD, 8'h00);
    chk("R6 zero start irq", {15'h0, irq_n}, 16'h1);

    // R8 set wins over same-edge clear: count 2, clear lands on expiry edge
    wr(4'h6, 8'h02);
    wr(4'h5, 8'h00);
    idle(1);
    wr(4'hD, 8'h40);
    rdchk("R8 set wins", 4'hD, 8'hC0);
    wr(4'hD, 8'h40);
    rdchk("R8 clear", 4'hD, 8'h00);

    // R7 timer 2
    wr(4'hE, 8'h7F);
    wr(4'hE, 8'hA0);
    rdchk("R7 t2 idle", 4'h8, 8'h00);
    wr(4'h9, 8'hAB);
    rdchk("R7 t2 latch", 4'h9, 8'hAB);
    rdchk("R7 latch no load", 4'h8, 8'h00);
    wr(4'h8, 8'h05);
    edges_to_irq(k, 50);
    chk("R7 t2 5 edges", 16'(k), 16'd5);
    rdchk("R7 flag bit5", 4'hD, 8'hA0);
    rdchk("R7 t2 zero", 4'h8, 8'h00);

    // R8/R11 selective clear with both flags
    wr(4'hD, 8'h7F);
    wr(4'h6, 8'h03);
    wr(4'h5, 8'h00);
    wr(4'h8, 8'h03);
    idle(6);
    rdchk("R8 both flags", 4'hD, 8'hE0);
    wr(4'hD, 8'h20);
    rdchk("R8 only bit5 cleared", 4'hD, 8'h40);
    chk("R11 masked flag", {15'h0, irq_n}, 16'h1);
    wr(4'hE, 8'hC0);
    chk("R11 enabled flag", {15'h0, irq_n}, 16'h0);
    rdchk("R10 bit7 set", 4'hD, 8'hC0);
    wr(4'hD, 8'hFF);
    rdchk("R8 clear all", 4'hD, 8'h00);
    chk("R11 released", {15'h0, irq_n}, 16'h1);

    summary();
  end
endmodule